// File: doc/BRIEF.md
# Segmented Serial Shift Register with Tap Loading

This block holds a set of independent serial shift register channels. Each channel is a chain of equal segments; the last bit of every segment is brought out as a tap. A channel has one serial data input that feeds the first bit on every rising edge of that channel's clock. It also has one write-enable control that sets the role of the taps.

With the write enable low, each tap drives the bit it sits on and the chain shifts as one long register. With the write enable high, the tap drivers are released, which the block signals with an output enable. The external values on the inner taps then feed the first bit of the following segment. A full channel can therefore be filled in as many clocks as one segment is long. Bus-style sharing of the taps is modelled with a separate data-out port, data-in port and output enable per channel, so a surrounding bus can be resolved outside the block.

Each channel has its own clock, reset and write enable. One channel does not affect another.

Top module: `tapped_shreg`

## Requirements
- R1: A clock edge with the channel's rst_n low clears all bits of that channel. Afterwards, with wr_en low, every tap of that channel reads 0.
- R2: On every rising edge of a channel's clock, ser_in is stored into that channel's first bit. This holds at either wr_en level.
- R3: With wr_en low, tap_oe of the channel is 1. Tap k (k = 0..SEG_N-1, at bit index c*SEG_N+k of tap_out) shows the channel's bit (k+1)*SEG_W, counting bits from 1.
- R4: With wr_en low, a clock edge shifts the whole chain by one bit, so a value entering bit 1 reaches the last tap SEG_W*SEG_N edges later.
- R5: With wr_en high, tap_oe of the channel is 0 and all its tap_out bits are 0, standing for released drivers.
- R6: With wr_en high, a clock edge stores tap_in bit k (k = 0..SEG_N-2, at bit index c*(SEG_N-1)+k) into the first bit of segment k+1, in place of the preceding segment's last bit.
- R7: A full pattern loaded in SEG_W clocks with wr_en high reads back unchanged, highest bit first, on the last tap over SEG_W*SEG_N clocks with wr_en low.
- R8: Channels are independent: with one channel's clock held, its taps and contents stay unchanged while another channel shifts and loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | NUM_CH | Rising-edge clock, one per channel |
| rst_n | input | NUM_CH | Synchronous active-low clear, one per channel |
| wr_en | input | NUM_CH | Tap role select per channel: 0 = drive taps, 1 = load from taps |
| ser_in | input | NUM_CH | Serial data into bit 1 of each channel |
| tap_in | input | NUM_CH*(SEG_N-1) | External values on the inner taps, used when wr_en is 1 |
| tap_out | output | NUM_CH*SEG_N | Tap data, forced to 0 while released |
| tap_oe | output | NUM_CH | Tap driver enable per channel, the inverse of wr_en |

## Verification
The bench builds the block with its defaults: two channels of four 16-bit segments, so 64 bits per channel. This gives the full 16-clock segmented load followed by a 64-clock serial readback. A behavioural model of each channel is compared with every tap and enable after each edge. Gating the second channel's clock makes independence observable. A random phase mixes wr_en toggling mid-stream with the inner tap values resolved from a bus that the bench drives.

// File: rtl/tapped_shreg_pkg.sv
// Shared definitions for the segmented tapped shift register.
// Assumes nothing beyond the default geometry given here.
package tapped_shreg_pkg;
    localparam int DEF_SEG_W = 16;
    localparam int DEF_SEG_N = 4;

    // Role of the taps, selected by the write enable.
    typedef enum logic {
        TAP_DRIVE = 1'b0,
        TAP_LOAD  = 1'b1
    } tap_mode_e;
endpackage

// File: rtl/tsr_segment.sv
// One segment of the chain: a SEG_W-bit shift register whose first bit
// takes din on every rising edge. Assumes SEG_W >= 2.
module tsr_segment #(
    parameter int SEG_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic head,
    output logic tail
);
    logic [SEG_W-1:0] bits_q;

    // Shift one position per edge, clearing on synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= {bits_q[SEG_W-2:0], din};
        end
    end

    assign head = bits_q[0];
    assign tail = bits_q[SEG_W-1];

    // R2/R4/R6: whatever reaches din is in the first bit after the edge.
    p_head_takes_din_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> head == $past(din));

    // R1: a reset edge leaves the segment empty.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (head == 1'b0 && tail == 1'b0));
endmodule

// File: rtl/tsr_chain.sv
// One channel: SEG_N segments in series. The write enable selects
// whether each inner segment is fed by its predecessor or by the
// external tap value, and whether the taps are driven. Assumes SEG_N >= 2.
module tsr_chain
    import tapped_shreg_pkg::*;
#(
    parameter int SEG_W = DEF_SEG_W,
    parameter int SEG_N = DEF_SEG_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             ser_in,
    input  logic [SEG_N-2:0] tap_in,
    output logic [SEG_N-1:0] tap_out,
    output logic             tap_oe
);
    tap_mode_e        mode;
    logic [SEG_N-1:0] seg_din;
    logic [SEG_N-1:0] seg_head;
    logic [SEG_N-1:0] seg_tail;

    // Decode the tap role from the write enable.
    always_comb mode = wr_en ? TAP_LOAD : TAP_DRIVE;

    assign seg_din[0] = ser_in;

    for (genvar k = 0; k < SEG_N; k++) begin : g_seg
        if (k > 0) begin : g_feed
            // Inner segment input: external tap in load mode, else predecessor.
            always_comb seg_din[k] = (mode == TAP_LOAD) ? tap_in[k-1] : seg_tail[k-1];

            // R6: in load mode the segment head follows the external tap.
            p_load_from_tap_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && wr_en) |=> seg_head[k] == $past(tap_in[k-1]));

            // R4: in drive mode the segments form one continuous chain.
            p_chain_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && !wr_en) |=> seg_head[k] == $past(seg_tail[k-1]));
        end

        tsr_segment #(.SEG_W(SEG_W)) u_seg (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (seg_din[k]),
            .head (seg_head[k]),
            .tail (seg_tail[k])
        );
    end

    // Drive taps only in drive mode; released taps read as 0.
    always_comb begin
        tap_oe  = (mode == TAP_DRIVE);
        tap_out = tap_oe ? seg_tail : '0;
    end
endmodule

// File: rtl/tapped_shreg.sv
// Top: NUM_CH independent channels, each with its own clock, reset and
// write enable. Assumes each clock is free of glitches.
module tapped_shreg
    import tapped_shreg_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int SEG_W  = DEF_SEG_W,
    parameter int SEG_N  = DEF_SEG_N
) (
    input  logic [NUM_CH-1:0]           clk,
    input  logic [NUM_CH-1:0]           rst_n,
    input  logic [NUM_CH-1:0]           wr_en,
    input  logic [NUM_CH-1:0]           ser_in,
    input  logic [NUM_CH*(SEG_N-1)-1:0] tap_in,
    output logic [NUM_CH*SEG_N-1:0]     tap_out,
    output logic [NUM_CH-1:0]           tap_oe
);
    localparam int IN_W = SEG_N - 1;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tsr_chain #(.SEG_W(SEG_W), .SEG_N(SEG_N)) u_chain (
            .clk    (clk[c]),
            .rst_n  (rst_n[c]),
            .wr_en  (wr_en[c]),
            .ser_in (ser_in[c]),
            .tap_in (tap_in[c*IN_W +: IN_W]),
            .tap_out(tap_out[c*SEG_N +: SEG_N]),
            .tap_oe (tap_oe[c])
        );

        // R5: a channel in load mode releases and blanks all its taps.
        p_taps_released_r5: assert property (@(posedge clk[c]) disable iff (!rst_n[c])
            wr_en[c] |-> (!tap_oe[c] && tap_out[c*SEG_N +: SEG_N] == '0));

        // R3: a channel in drive mode enables its tap drivers.
        p_taps_driven_r3: assert property (@(posedge clk[c]) disable iff (!rst_n[c])
            !wr_en[c] |-> tap_oe[c]);
    end
endmodule

// File: tb/tapped_shreg_tb_top.sv
module tapped_shreg_tb_top;
    localparam int NUM_CH = 2;
    localparam int SEG_W  = 16;
    localparam int SEG_N  = 4;
    localparam int TOT    = SEG_W * SEG_N;

    logic                         clk_a = 1'b0;
    logic                         run_b = 1'b1;
    logic [NUM_CH-1:0]            clk;
    logic [NUM_CH-1:0]            rst_n  = '0;
    logic [NUM_CH-1:0]            wr_en  = '0;
    logic [NUM_CH-1:0]            ser_in = '0;
    logic [NUM_CH*(SEG_N-1)-1:0]  ext_drv = '0;
    logic [NUM_CH*(SEG_N-1)-1:0]  tap_in;
    logic [NUM_CH*SEG_N-1:0]      tap_out;
    logic [NUM_CH-1:0]            tap_oe;

    int checks = 0;
    int errors = 0;
    logic [TOT-1:0] mdl [NUM_CH];

    always #2.5 clk_a = ~clk_a;
    assign clk[0] = clk_a;
    assign clk[1] = clk_a & run_b;

    // Resolve each inner tap as a shared bus: the block drives when enabled.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_bus
        for (genvar k = 0; k < SEG_N-1; k++) begin : g_t
            assign tap_in[c*(SEG_N-1)+k] = tap_oe[c] ? tap_out[c*SEG_N+k]
                                                     : ext_drv[c*(SEG_N-1)+k];
        end
    end

    tapped_shreg #(.NUM_CH(NUM_CH), .SEG_W(SEG_W), .SEG_N(SEG_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ser_in(ser_in),
        .tap_in(tap_in), .tap_out(tap_out), .tap_oe(tap_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [TOT-1:0] act,
                       input logic [TOT-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: index 0 is bit 1 of the channel.
    task automatic model_step(input int c);
        logic [TOT-1:0] nx;
        if (!rst_n[c]) begin
            mdl[c] = '0;
            return;
        end
        nx = mdl[c] << 1;
        nx[0] = ser_in[c];
        if (wr_en[c])
            for (int k = 1; k < SEG_N; k++)
                nx[k*SEG_W] = tap_in[c*(SEG_N-1)+k-1];
        mdl[c] = nx;
    endtask

    initial begin
        mdl[0] = '0;
        mdl[1] = '0;
    end
    always @(posedge clk[0]) model_step(0);
    always @(posedge clk[1]) model_step(1);

    // Per-edge comparison of every tap and enable against the model.
    bit cmp_on = 1'b0;
    always @(posedge clk_a) begin
        #1;
        if (cmp_on) begin
            for (int c = 0; c < NUM_CH; c++) begin
                logic [SEG_N-1:0] et;
                for (int k = 0; k < SEG_N; k++)
                    et[k] = wr_en[c] ? 1'b0 : mdl[c][(k+1)*SEG_W-1];
                if (wr_en[c])
                    chk(tap_out[c*SEG_N +: SEG_N] == et && !tap_oe[c], "R5 released taps",
                        TOT'({tap_oe[c], tap_out[c*SEG_N +: SEG_N]}), TOT'({1'b0, et}));
                else
                    chk(tap_out[c*SEG_N +: SEG_N] == et && tap_oe[c], "R3/R4/R6 tap values",
                        TOT'({tap_oe[c], tap_out[c*SEG_N +: SEG_N]}), TOT'({1'b1, et}));
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [TOT-1:0] pat;
        logic [TOT-1:0] got;
        logic [SEG_N-1:0] held;

        repeat (3) @(negedge clk_a);
        // R1: after reset edges with wr_en low, all taps read 0.
        chk(tap_out == '0 && tap_oe == '1, "R1 reset state", TOT'(tap_out), '0);
        rst_n = '1;
        cmp_on = 1'b1;

        // R2/R4: a single 1 walks from bit 1 to the last tap in 64 edges.
        ser_in[0] = 1'b1;
        @(negedge clk_a);
        ser_in[0] = 1'b0;
        for (int t = 1; t < TOT; t++) @(negedge clk_a);
        chk(tap_out[SEG_N-1] == 1'b1, "R4 walking bit at last tap",
            TOT'(tap_out[SEG_N-1]), 1);
        @(negedge clk_a);
        chk(tap_out[SEG_N-1] == 1'b0, "R4 walking bit leaves",
            TOT'(tap_out[SEG_N-1]), 0);

        // R7/R8: segmented load of channel 0 with channel 1 clock held.
        repeat (10) begin
            ser_in[1] = 1'b1;
            @(negedge clk_a);
        end
        ser_in[1] = 1'b0;
        held = tap_out[SEG_N +: SEG_N];
        run_b = 1'b0;
        pat = 64'hC3A5_0F1E_9B62_7D48;
        for (int j = 0; j < SEG_W; j++) begin
            wr_en[0] = 1'b1;
            ser_in[0] = pat[SEG_W-1-j];
            for (int k = 1; k < SEG_N; k++)
                ext_drv[k-1] = pat[k*SEG_W + SEG_W-1-j];
            @(negedge clk_a);
        end
        wr_en[0] = 1'b0;
        ser_in[0] = 1'b0;
        chk(tap_out[SEG_N +: SEG_N] == held, "R8 held channel unchanged",
            TOT'(tap_out[SEG_N +: SEG_N]), TOT'(held));
        #1;
        got[TOT-1] = tap_out[SEG_N-1];
        for (int t = 1; t < TOT; t++) begin
            @(posedge clk_a);
            #2;
            got[TOT-1-t] = tap_out[SEG_N-1];
        end
        chk(got == pat, "R7 load then serial readback", got, pat);
        @(negedge clk_a);
        run_b = 1'b1;

        // R1: reset of channel 1 only clears it; channel 0 keeps shifting.
        rst_n[1] = 1'b0;
        @(negedge clk_a);
        rst_n[1] = 1'b1;
        chk(tap_out[SEG_N +: SEG_N] == '0, "R1 channel reset",
            TOT'(tap_out[SEG_N +: SEG_N]), 0);

        // Random phase: mixed wr_en, serial and bus values on both channels.
        for (int i = 0; i < 600; i++) begin
            wr_en   = NUM_CH'($urandom_range(0, 3));
            ser_in  = NUM_CH'($urandom);
            ext_drv = ($bits(ext_drv))'($urandom);
            run_b   = ($urandom_range(0, 7) != 0);
            @(negedge clk_a);
        end
        run_b = 1'b1;
        wr_en = '0;
        @(negedge clk_a);
        cmp_on = 1'b0;
        #1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule